// File: doc/BRIEF.md
# Early-Restart Cache Line Refill Controller

This block services read misses for a direct-mapped cache whose lines are four words long. When the processor asks for a word that is not present, the controller raises a stall and fetches the line from a slower main memory. It fetches one word per memory transaction. Each returned word is written straight into the line storage. As soon as the word the processor asked for has landed, the stall drops and the processor continues. The remaining words of the line keep arriving in the background.

While that background fill runs, the processor may touch the cache again. A hit on any other line is served at once. For the line that is still filling, the controller keeps a per-word arrival mask. A word that has already arrived is returned without a stall, and a word still outstanding holds the processor until its beat lands. A miss on a different line waits until the current refill has finished. The fetch order is chosen per miss: ascending from word 0, or requested word first with wrap-around. Addresses on both ports are word addresses: bits [1:0] select the word in the line, the next bits select the line index, and the upper bits form the tag.

Top module: `early_restart_refill`

## Requirements
- R1: After reset every line is invalid and `mem_req_o` is low, and `cpu_stall_o` is low in any cycle where `cpu_req_i` is low.
- R2: A read of a word that is not present raises `cpu_stall_o` in the same cycle. The first memory request of the refill carries the missing line's tag and index.
- R3: With `crit_first_i` high when the miss is accepted, the line's words are requested in the order w, w+1, w+2, w+3 modulo 4, where w is address bits [1:0] of the missed address.
- R4: With `crit_first_i` low when the miss is accepted, the words are requested in the order 0, 1, 2, 3, whatever word was asked for.
- R5: `cpu_stall_o` falls in the cycle after the beat that carries the requested word, and `cpu_rdata_o` then equals that beat's data.
- R6: Each refill issues exactly four memory requests, with at most one word outstanding at a time. `mem_req_o` stays high with a stable `mem_addr_o` until `mem_gnt_i` is seen.
- R7: During a refill, a read of a word of the filling line that has already arrived completes without a stall. A read of a word that has not yet arrived stalls until the cycle after its beat.
- R8: During the background fill, a read that hits a different line completes without a stall and returns that line's data.
- R9: A miss on a different line during a refill stalls. Its first memory request is issued only after the last beat of the current refill.
- R10: After a refill completes, all four words of the line hit without a stall and return the data of their beats.
- R11: A `mem_valid_i` pulse while no word is outstanding writes nothing into the line storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor read request, held while stalled |
| cpu_addr_i | input | ADDR_W | Processor word address |
| crit_first_i | input | 1 | Fetch order for a new miss: 1 requested word first, 0 ascending |
| cpu_stall_o | output | 1 | Processor must hold its request |
| cpu_rdata_o | output | DATA_W | Read data, valid when request is high and stall is low |
| mem_req_o | output | 1 | Memory word request |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_valid_i | input | 1 | Data beat strobe |
| mem_data_i | input | DATA_W | Data word of the beat |

## Verification
The bench goes after the release point. It checks that the stall drops exactly one cycle after the requested word's beat. A design that waited for the whole line, or that released a cycle early, would be off by cycles, or would return stale data. Back-to-back reads of not-yet-arrived words in the filling line catch a design that trusts the line valid bit alone: such a design would return garbage instead of stalling. A hit on another line during the fill, and a miss queued behind it, expose a controller that blocks all traffic, or one that starts a second refill before the first ends and scrambles the request order. A stray data strobe while idle catches a write path that is not gated by an outstanding word; such a path would overwrite the last line filled.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/erc_line_store.sv
module erc_line_store #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 11,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tag_we_i,
  input  logic [TAG_W-1:0]  wr_tag_i
);
  logic [DATA_W-1:0] data_q [LINES][WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_vec;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                v_q <= 1'b0;
      else if (tag_we_i && wr_idx_i == IDX_W'(l)) v_q <= 1'b1;
    end
    assign valid_vec[l] = v_q;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i)  data_q[wr_idx_i][wr_word_i] <= wr_data_i;
    if (tag_we_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign rd_data_o  = data_q[rd_idx_i][rd_word_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_valid_o = valid_vec[rd_idx_i];
endmodule

// File: rtl/erc_fill_seq.sv
module erc_fill_seq
  import erc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic [WORD_W-1:0] start_word_i,
  input  logic              crit_first_i,
  output logic              busy_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [WORDS-1:0]  arrived_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              tag_we_o
);
  fill_state_e       state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] cur_q;
  logic [WORD_W-1:0] cnt_q;
  logic [WORDS-1:0]  arrived_q;
  logic              beat;
  logic              last_beat;

  assign beat      = (state_q == FS_WAIT) && mem_valid_i;
  assign last_beat = cnt_q == WORD_W'(WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FS_IDLE;
      tag_q     <= '0;
      idx_q     <= '0;
      cur_q     <= '0;
      cnt_q     <= '0;
      arrived_q <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (start_i) begin
          tag_q   <= start_tag_i;
          idx_q   <= start_idx_i;
          cur_q   <= crit_first_i ? start_word_i : '0;
          cnt_q   <= '0;
          state_q <= FS_REQ;
        end
        FS_REQ: if (mem_gnt_i) state_q <= FS_WAIT;
        FS_WAIT: if (mem_valid_i) begin
          cur_q <= cur_q + 1'b1;  // wraps within the line
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) begin
            arrived_q <= '0;
            state_q   <= FS_IDLE;
          end else begin
            arrived_q[cur_q] <= 1'b1;
            state_q          <= FS_REQ;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != FS_IDLE;
  assign fill_tag_o = tag_q;
  assign fill_idx_o = idx_q;
  assign arrived_o  = arrived_q;
  assign mem_req_o  = state_q == FS_REQ;
  assign mem_addr_o = {tag_q, idx_q, cur_q};
  assign wr_en_o    = beat;
  assign wr_word_o  = cur_q;
  assign wr_data_o  = mem_data_i;
  assign tag_we_o   = beat && (cnt_q == '0);  // new tag and valid with first word
endmodule

// File: rtl/erc_lookup.sv
module erc_lookup #(
  parameter int TAG_W = 11,
  parameter int IDX_W = 3,
  parameter int WORDS = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              req_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic              rd_valid_i,
  input  logic              busy_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [WORDS-1:0]  arrived_i,
  output logic              hit_o
);
  logic in_fill;
  logic line_hit;

  assign in_fill  = busy_i && (idx_i == fill_idx_i) && (tag_i == fill_tag_i);
  assign line_hit = rd_valid_i && (rd_tag_i == tag_i);
  // Line in flight: only words already landed count as hits
  assign hit_o    = req_i && (in_fill ? arrived_i[word_i] : line_hit);
endmodule

// File: rtl/early_restart_refill.sv
module early_restart_refill #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              crit_first_i,
  output logic              cpu_stall_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WORD_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - WORD_W;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WORD_W-1:0] req_word;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid;
  logic              busy;
  logic [TAG_W-1:0]  fill_tag;
  logic [IDX_W-1:0]  fill_idx;
  logic [WORDS-1:0]  arrived;
  logic              wr_en;
  logic [WORD_W-1:0] wr_word;
  logic [DATA_W-1:0] wr_data;
  logic              tag_we;
  logic              hit;
  logic              start;

  assign req_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign req_idx  = cpu_addr_i[WORD_W +: IDX_W];
  assign req_word = cpu_addr_i[WORD_W-1:0];

  erc_line_store #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(req_idx), .rd_word_i(req_word),
    .rd_data_o(cpu_rdata_o), .rd_tag_o(rd_tag), .rd_valid_o(rd_valid),
    .wr_en_i(wr_en), .wr_idx_i(fill_idx), .wr_word_i(wr_word), .wr_data_i(wr_data),
    .tag_we_i(tag_we), .wr_tag_i(fill_tag)
  );

  erc_fill_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .start_tag_i(req_tag), .start_idx_i(req_idx),
    .start_word_i(req_word), .crit_first_i,
    .busy_o(busy), .fill_tag_o(fill_tag), .fill_idx_o(fill_idx), .arrived_o(arrived),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_valid_i, .mem_data_i,
    .wr_en_o(wr_en), .wr_word_o(wr_word), .wr_data_o(wr_data), .tag_we_o(tag_we)
  );

  erc_lookup #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .WORDS(WORDS)
  ) u_look (
    .req_i(cpu_req_i), .tag_i(req_tag), .idx_i(req_idx), .word_i(req_word),
    .rd_tag_i(rd_tag), .rd_valid_i(rd_valid),
    .busy_i(busy), .fill_tag_i(fill_tag), .fill_idx_i(fill_idx), .arrived_i(arrived),
    .hit_o(hit)
  );

  assign cpu_stall_o = cpu_req_i && !hit;
  assign start       = cpu_stall_o && !busy;  // other-line miss waits for idle
endmodule

// File: rtl/early_restart_refill_chk.sv
module early_restart_refill_chk #(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_stall_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_gnt_i,
  input logic              mem_valid_i
);
  localparam int WORD_W = $clog2(WORDS);

  logic              outstanding_q;
  logic [WORD_W-1:0] beat_cnt_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outstanding_q <= 1'b0;
      beat_cnt_q    <= '0;
      last_addr_q   <= '0;
    end else begin
      if (mem_req_o && mem_gnt_i) begin
        outstanding_q <= 1'b1;
        last_addr_q   <= mem_addr_o;
      end else if (outstanding_q && mem_valid_i) begin
        outstanding_q <= 1'b0;
        beat_cnt_q    <= beat_cnt_q + 1'b1;
      end
    end
  end

  assign next_addr = {last_addr_q[ADDR_W-1:WORD_W], last_addr_q[WORD_W-1:0] + 1'b1};

  AST_STALL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> !cpu_stall_o);  // R1
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));  // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_q |-> !mem_req_o);  // R6
  AST_WRAP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && beat_cnt_q != '0 |-> mem_addr_o == next_addr);  // R3
  AST_RELEASE_ON_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_stall_o) && cpu_req_i && $past(cpu_req_i) && $stable(cpu_addr_i)
      |-> $past(mem_valid_i));  // R5
endmodule

bind early_restart_refill early_restart_refill_chk #(
  .ADDR_W(ADDR_W), .WORDS(WORDS)
) u_chk (.*);

// File: tb/early_restart_refill_test.sv
module early_restart_refill_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          crit = 1'b0;
  logic          cpu_stall;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_gnt = 1'b0;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_data = '0;

  always #4 clk = ~clk;  // 125 MHz

  early_restart_refill uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
    .crit_first_i(crit), .cpu_stall_o(cpu_stall), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  int            lat = 0;
  int            mstate = 0;
  int            mcnt = 0;
  logic [AW-1:0] maddr = '0;
  logic [AW-1:0] glog [64];
  int            gn = 0;
  int            beat_cyc [4];
  int            stray_cnt = 0;
  int            stray_done = 0;

  function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
    return {16'hC0DE, a};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mstate = 0; mem_gnt = 0; mem_valid = 0;
    end else begin
      mem_gnt = 0;
      if (mstate == 2) begin
        mem_valid = 0; mstate = 0;
      end else if (mstate == 1) begin
        if (mcnt == 0) begin
          mem_valid = 1; mem_data = fdat(maddr);
          beat_cyc[maddr[1:0]] = cyc + 1;
          mstate = 2;
        end else mcnt--;
      end
      if (mstate == 0 && stray_cnt != stray_done && !mem_req) begin
        mem_valid = 1; mem_data = 32'hDEAD_BEEF; stray_done++; mstate = 2;
      end else if (mstate == 0 && mem_req) begin
        mem_gnt = 1; maddr = mem_addr;
        if (gn < 64) glog[gn] = mem_addr;
        gn++; mcnt = lat; mstate = 1;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic cpu_read(input logic [AW-1:0] a, input bit cf,
                          output int waited, output int rel, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; crit = cf;
    #1;
    waited = 0;
    while (cpu_stall === 1'b1 && waited < 2000) begin
      @(negedge clk); #1; waited++;
    end
    rel = cyc; d = cpu_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    cpu_req = 0;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 stall idle", 32'(cpu_stall), 0);
    chk("R1 mem_req idle", 32'(mem_req), 0);
  endtask

  task automatic t_crit();
    int w, r, g0; logic [DW-1:0] d;
    lat = 3; g0 = gn;
    cpu_read(16'h0012, 1, w, r, d);
    chk("R2 miss stalls", 32'(w > 0), 1);
    chk("R2 first addr", 32'(glog[g0]), 32'h0012);
    chk("R5 release cycle", 32'(r), 32'(beat_cyc[2]));
    chk("R5 data", d, fdat(16'h0012));
    cpu_read(16'h0013, 1, w, r, d);
    chk("R7 pending word stalls", 32'(w > 0), 1);
    chk("R7 release cycle w3", 32'(r), 32'(beat_cyc[3]));
    chk("R7 data w3", d, fdat(16'h0013));
    cpu_read(16'h0010, 1, w, r, d);
    chk("R7 release cycle w0", 32'(r), 32'(beat_cyc[0]));
    chk("R7 data w0", d, fdat(16'h0010));
    cpu_read(16'h0012, 1, w, r, d);
    chk("R7 arrived word no stall", 32'(w), 0);
    chk("R7 fill still running", 32'(gn - g0 <= 4 && beat_cyc[1] < beat_cyc[0]), 1);
    wait_idle();
    chk("R6 four requests", 32'(gn - g0), 4);
    chk("R3 order 1", 32'(glog[g0+1]), 32'h0013);
    chk("R3 order 2", 32'(glog[g0+2]), 32'h0010);
    chk("R3 order 3", 32'(glog[g0+3]), 32'h0011);
    cpu_read(16'h0011, 1, w, r, d);
    chk("R10 full line hit", 32'(w), 0);
    chk("R10 data", d, fdat(16'h0011));
  endtask

  task automatic t_asc();
    int w, r, g0; logic [DW-1:0] d;
    lat = 1; g0 = gn;
    cpu_read(16'h0027, 0, w, r, d);
    chk("R5 asc release cycle", 32'(r), 32'(beat_cyc[3]));
    chk("R5 asc data", d, fdat(16'h0027));
    wait_idle();
    chk("R6 asc four requests", 32'(gn - g0), 4);
    for (int k = 0; k < 4; k++)
      chk("R4 ascending order", 32'(glog[g0+k]), 32'h0024 + k);
  endtask

  task automatic t_other();
    int w, r, g0, gm; logic [DW-1:0] d;
    lat = 4; g0 = gn;
    cpu_read(16'h0040, 1, w, r, d);
    chk("R5 other release", 32'(r), 32'(beat_cyc[0]));
    cpu_read(16'h0011, 1, w, r, d);
    gm = gn;
    chk("R8 hit during fill no stall", 32'(w), 0);
    chk("R8 data", d, fdat(16'h0011));
    chk("R8 fill incomplete", 32'(gm - g0 < 4), 1);
    cpu_read(16'h0058, 1, w, r, d);
    chk("R9 other miss stalls", 32'(w > 0), 1);
    chk("R9 data", d, fdat(16'h0058));
    wait_idle();
    chk("R9 prior refill finished", 32'(glog[g0+3]), 32'h0043);
    chk("R9 queued miss after", 32'(glog[g0+4]), 32'h0058);
    chk("R6 two refills", 32'(gn - g0), 8);
  endtask

  task automatic t_stray();
    int w, r; logic [DW-1:0] d;
    @(negedge clk);
    cpu_req = 0; stray_cnt++;
    repeat (5) @(negedge clk);
    chk("R11 stray beat sent", 32'(stray_done), 32'(stray_cnt));
    cpu_read(16'h0058, 1, w, r, d);
    chk("R11 no stall", 32'(w), 0);
    chk("R11 word0 intact", d, fdat(16'h0058));
    cpu_read(16'h005B, 1, w, r, d);
    chk("R11 word3 intact", d, fdat(16'h005B));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_crit();
    t_asc();
    t_other();
    t_stray();
    finish_run();
  end
endmodule